// File: doc/BRIEF.md
# Dual-Lane Bit-Serial Multiplier

This block multiplies two unsigned WIDTH-bit numbers. The multiplicand is presented as a parallel word together with a start strobe. The multiplier follows as a stream of two-bit pairs, one pair per valid cycle, beginning with the lowest pair. The product comes back as a stream of two-bit pairs, also lowest pair first. The stream holds 2*WIDTH bits and takes WIDTH steps to deliver. A done flag marks the final pair.

Inside, the even-position multiplier bits and the odd-position multiplier bits go to two independent lanes. Each lane has its own partial-product gate and its own radix-4 accumulator. The odd lane runs one register stage behind the even lane, which models the two lanes sitting in different clock phases. A carry-save merge stage adds the even digit and twice the odd digit to a small carry register. Each step it emits two final product bits. Because two multiplier bits are taken per step, the block is twice as fast as a one-bit-per-cycle shift-add unit.

WIDTH must be even. After start, the block takes the first WIDTH/2 valid input cycles as the multiplier pairs. It then runs WIDTH/2 flush steps on its own to bring out the upper half of the product.

Top module: `twin_serial_mult`

## Requirements
- R1: After reset, `prod_valid` and `prod_done` are low, and they stay low until an operation has been started.
- R2: A `start` pulse sampled while the block is idle captures `mcand`. The next WIDTH/2 cycles that have `mplier_valid` high each supply one multiplier pair. In each pair, `mplier_bits[0]` is multiplier bit 2k and `mplier_bits[1]` is bit 2k+1, with k counting up from 0. A `mplier_valid` in the same cycle as the accepted `start` is ignored.
- R3: The k-th output pair on `prod_bits` carries product bits {2k+1, 2k}, with bit 2k on `prod_bits[0]`. Exactly WIDTH pairs are emitted, and together they form the full 2*WIDTH-bit unsigned product.
- R4: Product pair k, for k below WIDTH/2, appears with `prod_valid` high exactly two cycles after the input cycle that carried multiplier pair k. The upper WIDTH/2 pairs follow on the consecutive cycles right after the pair that belongs to the last input.
- R5: A cycle without `mplier_valid` during the input phase consumes nothing. Two cycles later `prod_valid` is low, and the remaining pairs keep their results.
- R6: `prod_done` is high for one cycle only, together with the final (WIDTH-th) output pair.
- R7: A `start` sampled while an operation is in progress is ignored. Neither the multiplicand in use nor the product changes.
- R8: A `start` sampled in the cycle right after `prod_done` is accepted and begins a new operation.
- R9: `mplier_valid` is ignored while the block is idle and during the flush phase. No extra output pair results from it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins an operation when idle |
| mcand | input | WIDTH | Parallel multiplicand, captured on accepted start |
| mplier_valid | input | 1 | Marks a multiplier pair on `mplier_bits` |
| mplier_bits | input | 2 | Multiplier pair: [0] even-position bit, [1] odd-position bit |
| prod_valid | output | 1 | Marks a product pair on `prod_bits` |
| prod_bits | output | 2 | Product pair, lower bit on [0] |
| prod_done | output | 1 | High with the last product pair |

## Verification
Each input pair that is accepted has its product pair due exactly two clock edges after the edge that samples it. The flush pairs follow on the next WIDTH/2 edges, and the done flag comes on the last of them. The bench drives inputs on the falling edge and records the rising-edge number at which each input will be sampled. From that number it schedules every expected pair, with its value and done flag, at the correct later edge. On every falling edge it compares the outputs with that schedule, and any cycle with no scheduled entry must show no valid output. Gaps, stray strobes and ignored valid inputs add nothing to the schedule, so any output they cause shows up as a mismatch in that same cycle.

// File: rtl/twin_mul_pkg.sv
package twin_mul_pkg;

    // Sequencer phases of one multiplication
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_LOAD  = 2'd1,
        SEQ_FLUSH = 2'd2,
        SEQ_DRAIN = 2'd3
    } seq_state_e;

    localparam int DIGIT_W = 2;   // radix-4 digit emitted per step
    localparam int CARRY_W = 2;   // merge carry, max value 3
    localparam int MERGE_W = 4;   // e + 2*o + c <= 12

    // Per-step command issued to the even lane
    typedef struct packed {
        logic       step;
        logic       last;
        logic [1:0] bits;
    } step_cmd_t;

    // Delayed command seen by the odd lane
    typedef struct packed {
        logic step;
        logic last;
        logic bval;
    } odd_cmd_t;

    // Combine the even digit with the odd digit (one bit heavier) and carry
    function automatic logic [MERGE_W-1:0] digit_merge(
        input logic [DIGIT_W-1:0] e,
        input logic [DIGIT_W-1:0] o,
        input logic [CARRY_W-1:0] c
    );
        logic [MERGE_W-1:0] ev;
        logic [MERGE_W-1:0] ov;
        logic [MERGE_W-1:0] cv;
        ev = {{(MERGE_W-DIGIT_W){1'b0}}, e};
        ov = {{(MERGE_W-DIGIT_W-1){1'b0}}, o, 1'b0};
        cv = {{(MERGE_W-CARRY_W){1'b0}}, c};
        return ev + ov + cv;
    endfunction

endpackage

// File: rtl/tsm_ctrl.sv
module tsm_ctrl
    import twin_mul_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  logic      in_valid,
    input  logic [1:0] in_bits,
    output logic      accept,
    output logic      busy,
    output step_cmd_t cmd
);

    localparam int PAIRS = WIDTH / 2;
    localparam int CNT_W = (WIDTH > 2) ? $clog2(WIDTH) : 1;
    localparam logic [CNT_W-1:0] LOAD_END  = CNT_W'(PAIRS - 1);
    localparam logic [CNT_W-1:0] STEP_END  = CNT_W'(WIDTH - 1);
    localparam logic [CNT_W-1:0] DRAIN_END = CNT_W'(1);

    seq_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        accept    = (state_q == SEQ_IDLE) && start;
        busy      = (state_q != SEQ_IDLE);
        cmd.step  = ((state_q == SEQ_LOAD) && in_valid) || (state_q == SEQ_FLUSH);
        cmd.bits  = (state_q == SEQ_LOAD) ? in_bits : 2'b00;
        cmd.last  = (state_q == SEQ_FLUSH) && (cnt_q == STEP_END);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (start) begin
                        state_q <= SEQ_LOAD;
                        cnt_q   <= '0;
                    end
                end
                SEQ_LOAD: begin
                    if (in_valid) begin
                        cnt_q <= cnt_q + 1'b1;
                        if (cnt_q == LOAD_END) begin
                            state_q <= SEQ_FLUSH;
                        end
                    end
                end
                SEQ_FLUSH: begin
                    if (cnt_q == STEP_END) begin
                        state_q <= SEQ_DRAIN;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                SEQ_DRAIN: begin
                    // two cycles for the odd lane and the merge stage to empty
                    if (cnt_q == DRAIN_END) begin
                        state_q <= SEQ_IDLE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    // R5: a gap during loading consumes no step
    a_r5_gap_holds_count: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_LOAD && !in_valid) |=> $stable(cnt_q));

    // R9: valid input while idle does not start loading
    a_r9_idle_stays: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_IDLE && !start) |=> (state_q == SEQ_IDLE));

    // R6: drain lasts exactly two cycles
    a_r6_drain_ends: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_DRAIN && cnt_q == DRAIN_END) |=> (state_q == SEQ_IDLE));

endmodule

// File: rtl/tsm_ppgen.sv
module tsm_ppgen #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] mcand,
    input  logic             sel,
    output logic [WIDTH-1:0] pp
);

    always_comb begin
        pp = sel ? mcand : '0;
    end

endmodule

// File: rtl/tsm_lane_acc.sv
module tsm_lane_acc
    import twin_mul_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  logic               step,
    input  logic [WIDTH-1:0]   pp,
    output logic [DIGIT_W-1:0] digit
);

    logic [WIDTH-1:0] acc_q;
    logic [WIDTH:0]   sum;

    always_comb begin
        sum = {1'b0, acc_q} + {1'b0, pp};
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            acc_q <= '0;
            digit <= '0;
        end else if (step) begin
            digit <= sum[DIGIT_W-1:0];
            acc_q <= {1'b0, sum[WIDTH:DIGIT_W]};
        end
    end

    // R5: no step, no change to the running sum
    a_r5_acc_holds: assert property (@(posedge clk) disable iff (rst)
        (!step && !clear) |=> $stable(acc_q));

endmodule

// File: rtl/tsm_merge.sv
module tsm_merge
    import twin_mul_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  logic               valid,
    input  logic               last,
    input  logic [DIGIT_W-1:0] e_digit,
    input  logic [DIGIT_W-1:0] o_digit,
    output logic               out_valid,
    output logic [1:0]         out_bits,
    output logic               out_done
);

    logic [CARRY_W-1:0] carry_q;
    logic [MERGE_W-1:0] total;

    always_comb begin
        total = digit_merge(e_digit, o_digit, carry_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_done  <= 1'b0;
            out_bits  <= '0;
            carry_q   <= '0;
        end else begin
            out_valid <= valid;
            out_done  <= valid && last;
            if (clear) begin
                carry_q <= '0;
            end else if (valid) begin
                out_bits <= total[1:0];
                carry_q  <= total[MERGE_W-1:2];
            end
        end
    end

    // R6: done only travels with a valid pair
    a_r6_done_with_valid: assert property (@(posedge clk) disable iff (rst)
        out_done |-> out_valid);

    // R6: done is a single-cycle flag
    a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
        out_done |=> !out_done);

    // R3: the full product fits, nothing left in the carry at the end
    a_r3_no_leftover_carry: assert property (@(posedge clk) disable iff (rst)
        out_done |-> (carry_q == '0));

endmodule

// File: rtl/twin_serial_mult.sv
module twin_serial_mult
    import twin_mul_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [WIDTH-1:0] mcand,
    input  logic             mplier_valid,
    input  logic [1:0]       mplier_bits,
    output logic             prod_valid,
    output logic [1:0]       prod_bits,
    output logic             prod_done
);

    localparam int LANES = 2;

    logic               accept;
    logic               busy;
    step_cmd_t          cmd;
    odd_cmd_t           odd_q;
    logic [WIDTH-1:0]   mcand_q;
    logic [DIGIT_W-1:0] even_dly_q;
    logic               mrg_valid_q;
    logic               mrg_last_q;

    logic [LANES-1:0]   lane_sel;
    logic [LANES-1:0]   lane_step;
    logic [WIDTH-1:0]   lane_pp    [LANES];
    logic [DIGIT_W-1:0] lane_digit [LANES];

    tsm_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .in_valid (mplier_valid),
        .in_bits  (mplier_bits),
        .accept   (accept),
        .busy     (busy),
        .cmd      (cmd)
    );

    // Operand hold, odd-lane skew and merge alignment registers
    always_ff @(posedge clk) begin
        if (rst) begin
            mcand_q     <= '0;
            odd_q       <= '0;
            even_dly_q  <= '0;
            mrg_valid_q <= 1'b0;
            mrg_last_q  <= 1'b0;
        end else begin
            if (accept) begin
                mcand_q <= mcand;
            end
            odd_q.step  <= cmd.step;
            odd_q.last  <= cmd.last;
            odd_q.bval  <= cmd.bits[1];
            even_dly_q  <= lane_digit[0];
            mrg_valid_q <= odd_q.step;
            mrg_last_q  <= odd_q.last;
        end
    end

    always_comb begin
        lane_sel[0]  = cmd.bits[0];
        lane_step[0] = cmd.step;
        lane_sel[1]  = odd_q.bval;
        lane_step[1] = odd_q.step;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        tsm_ppgen #(.WIDTH(WIDTH)) u_pp (
            .mcand (mcand_q),
            .sel   (lane_sel[g]),
            .pp    (lane_pp[g])
        );
        tsm_lane_acc #(.WIDTH(WIDTH)) u_acc (
            .clk   (clk),
            .rst   (rst),
            .clear (accept),
            .step  (lane_step[g]),
            .pp    (lane_pp[g]),
            .digit (lane_digit[g])
        );
    end

    tsm_merge u_merge (
        .clk       (clk),
        .rst       (rst),
        .clear     (accept),
        .valid     (mrg_valid_q),
        .last      (mrg_last_q),
        .e_digit   (even_dly_q),
        .o_digit   (lane_digit[1]),
        .out_valid (prod_valid),
        .out_bits  (prod_bits),
        .out_done  (prod_done)
    );

    // R7: multiplicand in use cannot change during an operation
    a_r7_mcand_locked: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(mcand_q));

    // R2: accepted start captures the presented multiplicand
    a_r2_capture: assert property (@(posedge clk) disable iff (rst)
        accept |=> (mcand_q == $past(mcand)));

    // R1: no output pair while idle and nothing in flight
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (!busy && !odd_q.step && !mrg_valid_q) |=> !prod_valid);

endmodule

// File: tb/twin_serial_mult_tb.sv
`timescale 1ns/1ps
module twin_serial_mult_tb;

    localparam int W    = 8;
    localparam int HALF = W / 2;

    logic         clk = 1'b0;
    logic         rst;
    logic         start;
    logic [W-1:0] mcand;
    logic         mplier_valid;
    logic [1:0]   mplier_bits;
    logic         prod_valid;
    logic [1:0]   prod_bits;
    logic         prod_done;

    always #4 clk = ~clk;

    twin_serial_mult #(.WIDTH(W)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .mcand        (mcand),
        .mplier_valid (mplier_valid),
        .mplier_bits  (mplier_bits),
        .prod_valid   (prod_valid),
        .prod_bits    (prod_bits),
        .prod_done    (prod_done)
    );

    int checks = 0;
    int errs   = 0;
    int cyc    = 0;
    bit chk_en = 1'b0;
    string cur_req = "R1";

    // expected-output schedule, keyed by rising-edge number
    int             q_edge [$];
    logic [1:0]     q_bits [$];
    bit             q_done [$];
    logic [2*W-1:0] q_prod [$];

    logic [2*W-1:0] asm_val = '0;
    int             asm_k   = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s at edge %0d: actual=%0h expected=%0h", req, what, cyc, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    // cycle-by-cycle comparison against the schedule
    always @(negedge clk) begin
        if (chk_en) begin
            if (q_edge.size() > 0 && q_edge[0] == cyc) begin
                check(prod_valid === 1'b1, "R4", "pair missing", 32'(prod_valid), 32'd1);
                check(prod_bits === q_bits[0], "R3", "pair value", 32'(prod_bits), 32'(q_bits[0]));
                check(prod_done === q_done[0], "R6", "done flag", 32'(prod_done), 32'(q_done[0]));
                asm_val[2*asm_k +: 2] = prod_bits;
                asm_k++;
                if (q_done[0]) begin
                    check(asm_val === q_prod[0], "R3", "reassembled product",
                          32'(asm_val), 32'(q_prod[0]));
                    asm_k   = 0;
                    asm_val = '0;
                end
                void'(q_edge.pop_front());
                void'(q_bits.pop_front());
                void'(q_done.pop_front());
                void'(q_prod.pop_front());
            end else begin
                check(prod_valid === 1'b0, cur_req, "unexpected valid", 32'(prod_valid), 32'd0);
                check(prod_done === 1'b0, "R6", "unexpected done", 32'(prod_done), 32'd0);
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        if (cyc > 150000) begin
            errs++;
            $display("FAIL R4 watchdog expired at edge %0d: actual=hung expected=finished", cyc);
            finish_run();
        end
    end

    task automatic sched(input int edge_n, input logic [1:0] bits, input bit done,
                         input logic [2*W-1:0] p);
        q_edge.push_back(edge_n);
        q_bits.push_back(bits);
        q_done.push_back(done);
        q_prod.push_back(p);
    endtask

    // One full multiplication; called right after a falling edge
    task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input int gap_pct,
                          input bit junk_in_start, input bit start_mid, input bit junk_flush);
        logic [2*W-1:0] p;
        int p_last;
        p = (2*W)'(a) * (2*W)'(b);
        start        = 1'b1;
        mcand        = a;
        mplier_valid = junk_in_start;
        mplier_bits  = 2'b11;
        @(negedge clk);
        start        = 1'b0;
        mplier_valid = 1'b0;
        p_last       = 0;
        for (int k = 0; k < HALF; k++) begin
            while ($urandom_range(99) < gap_pct) begin
                mplier_valid = 1'b0;
                mplier_bits  = 2'($urandom);
                if (start_mid) begin
                    start = 1'b1;
                    mcand = ~a;
                end
                @(negedge clk);
                start = 1'b0;
                mcand = a;
            end
            mplier_valid = 1'b1;
            mplier_bits  = b[2*k +: 2];
            if (start_mid) begin
                start = 1'b1;
                mcand = ~a;
            end
            p_last = cyc + 1;
            sched(p_last + 2, p[2*k +: 2], 1'b0, p);
            if (k == HALF - 1) begin
                for (int j = 1; j <= HALF; j++) begin
                    sched(p_last + 2 + j, p[2*(HALF-1+j) +: 2], (j == HALF), p);
                end
            end
            @(negedge clk);
            start = 1'b0;
            mcand = a;
        end
        mplier_valid = 1'b0;
        if (junk_flush) begin
            for (int i = 0; i <= HALF; i++) begin
                mplier_valid = 1'b1;
                mplier_bits  = 2'($urandom);
                start        = 1'b1;
                mcand        = ~a;
                @(negedge clk);
            end
            mplier_valid = 1'b0;
            start        = 1'b0;
            mcand        = a;
        end
        while (prod_done !== 1'b1) @(negedge clk);
    endtask

    initial begin
        rst          = 1'b1;
        start        = 1'b0;
        mcand        = '0;
        mplier_valid = 1'b0;
        mplier_bits  = 2'b00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(prod_valid === 1'b0, "R1", "valid after reset", 32'(prod_valid), 32'd0);
        check(prod_done === 1'b0, "R1", "done after reset", 32'(prod_done), 32'd0);
        chk_en = 1'b1;

        // R9: valid input while idle must not produce anything
        cur_req = "R9";
        mplier_valid = 1'b1;
        mplier_bits  = 2'b11;
        repeat (6) @(negedge clk);
        mplier_valid = 1'b0;
        repeat (3) @(negedge clk);

        // R3: corner operands, back to back (R8: each start follows done directly)
        cur_req = "R8";
        run_op('0, '0, 0, 1'b0, 1'b0, 1'b0);
        run_op('1, '1, 0, 1'b0, 1'b0, 1'b0);
        run_op(W'(1), W'(1), 0, 1'b0, 1'b0, 1'b0);
        run_op(W'(1), '1, 0, 1'b0, 1'b0, 1'b0);
        run_op('1, '0, 0, 1'b0, 1'b0, 1'b0);
        run_op(W'(8'hA5 & '1), W'(8'h5A & '1), 0, 1'b0, 1'b0, 1'b0);

        // R2: valid in the start cycle is ignored
        cur_req = "R2";
        run_op(W'(8'h37 & '1), W'(8'hC9 & '1), 0, 1'b1, 1'b0, 1'b0);

        // R5: gaps in the multiplier stream
        cur_req = "R5";
        run_op('1, '1, 50, 1'b0, 1'b0, 1'b0);
        run_op(W'(8'h6D & '1), W'(8'h93 & '1), 60, 1'b1, 1'b0, 1'b0);

        // R7: start strobes during loading; R9: valid and start during flush
        cur_req = "R7";
        run_op(W'(8'hD2 & '1), W'(8'h7F & '1), 40, 1'b0, 1'b1, 1'b0);
        cur_req = "R9";
        run_op(W'(8'h4B & '1), W'(8'hE1 & '1), 0, 1'b0, 1'b0, 1'b1);
        run_op('1, '1, 30, 1'b0, 1'b1, 1'b1);

        // random operands and patterns
        for (int n = 0; n < 150; n++) begin
            cur_req = "R4";
            run_op(W'($urandom), W'($urandom), (n % 3) * 25,
                   1'($urandom), 1'($urandom), 1'($urandom));
        end

        cur_req = "R1";
        repeat (8) @(negedge clk);
        check(q_edge.size() == 0, "R3", "pairs left unseen", 32'(q_edge.size()), 32'd0);
        finish_run();
    end

endmodule